// File: doc/BRIEF.md
# TCP Keepalive and Timeout Supervisor

This block watches the state of a single TCP connection and issues two kinds of one-cycle requests to the connection logic. While the connection is established and nothing arrives, it asks for a keepalive probe after a long idle period. If the peer still says nothing, it asks for further probes at a shorter retry interval, up to a retry limit. When the last retry interval also passes in silence, it asks for the connection to be dropped. Every received segment restarts this sequence from the beginning.

Separately, it times the opening and closing phases. If the connection stays in either phase for longer than the handshake timeout, it asks for an abort, once per phase entry. The supervisor does not build packets and does not hold the TCP state itself. It reads the state code from the connection state machine, and the state machine acts on the two request pulses. All periods are counted in clock ticks. The defaults suit a 125 MHz clock: a 5 s idle period, a 100 ms retry interval, 5 retries and a 1 s handshake timeout.

Top module: `tcp_liveness_supervisor`

## Requirements
- R1: While `rst_n` is low, `probe_req` and `abort_req` are low, whatever the other inputs do.
- R2: The connection state code is 3 bits: 0 closed, 1 listening, 2 opening, 3 established, 4 closing. The state changes to established (3) with `ka_en` high, and is sampled at clock edge k=0. With no segment received after that, the first `probe_req` pulse follows clock edge k=IDLE_TICKS.
- R3: After that first probe, with no segment received, exactly RETRY_LIMIT further probes follow, one every RETRY_TICKS edges.
- R4: `abort_req` pulses RETRY_TICKS edges after the last retry probe. After that, no pulse of either kind appears while the state stays established and no segment arrives.
- R5: A `seg_rx` pulse sampled at an edge in the established state restarts the idle period and clears the retry count. The next probe then follows IDLE_TICKS edges later, and the full retry sequence repeats.
- R6: While `ka_en` is low, or the KA_ENABLE parameter is 0, no probe or keepalive abort is produced. When `ka_en` returns high, a full idle period starts again.
- R7: Entering the opening (2) or closing (4) state starts the handshake watchdog. If the state has not changed, `abort_req` pulses HANDSHAKE_TICKS edges after entry, and only once.
- R8: A change between any two states restarts the handshake watchdog, including a change from opening directly to closing.
- R9: Leaving the established state clears the idle timer and the retry count. Re-entering it starts a full idle period.
- R10: Each pulse lasts one cycle, and `probe_req` and `abort_req` are never high in the same cycle. When both are due, the abort wins.
- R11: In the closed (0) and listening (1) states, neither output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conn_state | input | 3 | Connection state code (0 closed, 1 listening, 2 opening, 3 established, 4 closing) |
| seg_rx | input | 1 | One-cycle pulse for each segment received from the peer |
| ka_en | input | 1 | Run-time keepalive enable |
| probe_req | output | 1 | One-cycle request to send a keepalive probe |
| abort_req | output | 1 | One-cycle request to drop or abort the connection |

## Verification
A wrong internal state shows up as a pulse at the wrong edge, because both outputs are registered straight from terminal-count compares. A miscounted idle or retry timer moves the probe edge. A stale retry count after a segment changes how many probes come before the abort. A watchdog flag that is never cleared removes the abort after the next state change. The bench therefore compares both outputs at every edge of each timed scenario against an edge-by-edge expectation. Any such fault is seen within one idle period plus the retry sequence, which is at most IDLE_TICKS + (RETRY_LIMIT+1)·RETRY_TICKS edges.

// File: rtl/tcp_liveness_pkg.sv
// Package: shared state codes and keepalive phases for the liveness supervisor.
// Assumes the connection state machine uses the 3-bit codes listed below.
package tcp_liveness_pkg;

    typedef enum logic [2:0] {
        CS_CLOSED  = 3'd0,
        CS_LISTEN  = 3'd1,
        CS_OPENING = 3'd2,
        CS_OPEN    = 3'd3,
        CS_CLOSING = 3'd4
    } conn_state_e;

    typedef enum logic [1:0] {
        KA_QUIET   = 2'd0,
        KA_PROBING = 2'd1,
        KA_SPENT   = 2'd2
    } ka_phase_e;

    // True for the states that the handshake watchdog times.
    function automatic logic in_handshake(input logic [2:0] st);
        return (st == CS_OPENING) || (st == CS_CLOSING);
    endfunction

endpackage

// File: rtl/liveness_interval_timer.sv
// Module: tick counter with a run-time span. It flags the tick in which
// SPAN ticks of running have passed since the last clear or expiry.
// Assumes span >= 2. A clear takes precedence and suppresses the expiry.
module liveness_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] span,
    output logic         expire
);

    logic [W-1:0] cnt;

    assign expire = run && !clear && (cnt == span - W'(1));

    // Count running ticks; wrap to zero on expiry, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            if (expire) cnt <= '0;
            else        cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/liveness_keepalive_engine.sv
// Module: keepalive sequencer. It goes from a quiet idle period to probing
// at the retry interval, and to spent after RETRY_LIMIT unanswered retries.
// Assumes restart is high for one cycle at established entry or on a segment.
// While not active, it stays cleared.
module liveness_keepalive_engine
    import tcp_liveness_pkg::*;
#(
    parameter int W           = 30,
    parameter int IDLE_TICKS  = 625_000_000,
    parameter int RETRY_TICKS = 12_500_000,
    parameter int RETRY_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    output logic probe_fire,
    output logic drop_fire
);

    localparam int CW = $clog2(RETRY_LIMIT + 2);

    ka_phase_e     phase;
    logic [CW-1:0] retries;
    logic [W-1:0]  span;
    logic          clear;
    logic          run;
    logic          expire;
    logic          at_limit;

    assign clear    = restart || !active;
    assign run      = active && (phase != KA_SPENT);
    assign span     = (phase == KA_QUIET) ? W'(IDLE_TICKS) : W'(RETRY_TICKS);
    assign at_limit = (retries == CW'(RETRY_LIMIT));

    liveness_interval_timer #(.W(W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .run    (run),
        .span   (span),
        .expire (expire)
    );

    // Decode what each expiry means in the current phase.
    always_comb begin
        probe_fire = 1'b0;
        drop_fire  = 1'b0;
        if (expire) begin
            if (phase == KA_QUIET)        probe_fire = 1'b1;
            else if (phase == KA_PROBING) begin
                if (at_limit) drop_fire  = 1'b1;
                else          probe_fire = 1'b1;
            end
        end
    end

    // Advance the phase and the retry count on each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase   <= KA_QUIET;
            retries <= '0;
        end else if (expire) begin
            case (phase)
                KA_QUIET: begin
                    phase   <= KA_PROBING;
                    retries <= '0;
                end
                KA_PROBING: begin
                    if (at_limit) phase   <= KA_SPENT;
                    else          retries <= retries + CW'(1);
                end
                default: phase <= KA_SPENT;
            endcase
        end
    end

endmodule

// File: rtl/liveness_phase_watchdog.sv
// Module: one-shot timeout on the opening and closing phases.
// Assumes restart is high for one cycle on every state change. It fires at
// most once per phase entry.
module liveness_phase_watchdog #(
    parameter int W               = 30,
    parameter int HANDSHAKE_TICKS = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic watching,
    output logic timeout_fire
);

    logic fired;
    logic clear;
    logic run;

    assign clear = restart || !watching;
    assign run   = watching && !fired;

    liveness_interval_timer #(.W(W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .run    (run),
        .span   (W'(HANDSHAKE_TICKS)),
        .expire (timeout_fire)
    );

    // Remember a timeout until the state changes again.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) fired <= 1'b0;
        else if (timeout_fire) fired <= 1'b1;
    end

endmodule

// File: rtl/tcp_liveness_supervisor.sv
// Module: top of the keepalive and handshake-timeout supervisor.
// It detects state changes and feeds the keepalive engine and the phase
// watchdog. It registers both request pulses and gives the abort priority.
// Assumes conn_state is synchronous to clk and that all tick counts are >= 2.
module tcp_liveness_supervisor
    import tcp_liveness_pkg::*;
#(
    parameter int IDLE_TICKS      = 625_000_000,
    parameter int RETRY_TICKS     = 12_500_000,
    parameter int RETRY_LIMIT     = 5,
    parameter int HANDSHAKE_TICKS = 125_000_000,
    parameter bit KA_ENABLE       = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] conn_state,
    input  logic       seg_rx,
    input  logic       ka_en,
    output logic       probe_req,
    output logic       abort_req
);

    localparam int MAX_A = (IDLE_TICKS > RETRY_TICKS) ? IDLE_TICKS : RETRY_TICKS;
    localparam int MAX_T = (MAX_A > HANDSHAKE_TICKS) ? MAX_A : HANDSHAKE_TICKS;
    localparam int TW    = $clog2(MAX_T + 1);

    logic [2:0] prev_state;
    logic       entry;
    logic       ka_probe;
    logic       ka_drop;
    logic       wd_fire;
    logic       any_abort;

    assign entry     = (conn_state != prev_state);
    assign any_abort = ka_drop || wd_fire;

    // Track the previous state to detect every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_state <= CS_CLOSED;
        else        prev_state <= conn_state;
    end

    generate
        if (KA_ENABLE) begin : g_keepalive
            liveness_keepalive_engine #(
                .W           (TW),
                .IDLE_TICKS  (IDLE_TICKS),
                .RETRY_TICKS (RETRY_TICKS),
                .RETRY_LIMIT (RETRY_LIMIT)
            ) u_ka (
                .clk        (clk),
                .rst_n      (rst_n),
                .restart    (entry || seg_rx),
                .active     ((conn_state == CS_OPEN) && ka_en),
                .probe_fire (ka_probe),
                .drop_fire  (ka_drop)
            );
        end else begin : g_no_keepalive
            assign ka_probe = 1'b0;
            assign ka_drop  = 1'b0;
        end
    endgenerate

    liveness_phase_watchdog #(
        .W               (TW),
        .HANDSHAKE_TICKS (HANDSHAKE_TICKS)
    ) u_wd (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (entry),
        .watching     (in_handshake(conn_state)),
        .timeout_fire (wd_fire)
    );

    // Register the request pulses; an abort masks a probe in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_req <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            abort_req <= any_abort;
            probe_req <= ka_probe && !any_abort;
        end
    end

endmodule

// File: rtl/tcp_liveness_checker.sv
// Module: protocol checks on the supervisor ports, attached by bind.
// Assumes RETRY_TICKS >= 2 so that successive probes are never adjacent.
module tcp_liveness_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] conn_state,
    input logic       seg_rx,
    input logic       ka_en,
    input logic       probe_req,
    input logic       abort_req
);

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(probe_req && abort_req));

    p_probe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |=> !probe_req);

    p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    p_probe_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> $past(conn_state == 3'd3));

    p_abort_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $past(conn_state == 3'd2 || conn_state == 3'd3 || conn_state == 3'd4));

    p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> $past(ka_en));

    p_seg_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rx && conn_state == 3'd3) |=> !probe_req && !abort_req);

endmodule

bind tcp_liveness_supervisor tcp_liveness_checker u_liveness_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conn_state (conn_state),
    .seg_rx     (seg_rx),
    .ka_en      (ka_en),
    .probe_req  (probe_req),
    .abort_req  (abort_req)
);

// File: tb/tcp_liveness_supervisor_bench.sv
// Bench: a table of stimulus rows with expected pulse counts, then directed
// edge-exact tests. Inputs change at the falling edge; outputs are sampled there.
module tcp_liveness_supervisor_bench;

    localparam int P = 20;  // idle ticks
    localparam int R = 6;   // retry ticks
    localparam int L = 3;   // retry limit
    localparam int T = 15;  // handshake ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] conn_state = 3'd0;
    logic       seg_rx = 1'b0;
    logic       ka_en = 1'b1;
    logic       probe_req;
    logic       abort_req;

    int n_cmp = 0;
    int n_bad = 0;
    int r10_bad = 0;
    logic last_p = 1'b0;
    logic last_a = 1'b0;

    always #10 clk = ~clk;

    tcp_liveness_supervisor #(
        .IDLE_TICKS      (P),
        .RETRY_TICKS     (R),
        .RETRY_LIMIT     (L),
        .HANDSHAKE_TICKS (T),
        .KA_ENABLE       (1'b1)
    ) u_tcp_liveness_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .conn_state (conn_state),
        .seg_rx     (seg_rx),
        .ka_en      (ka_en),
        .probe_req  (probe_req),
        .abort_req  (abort_req)
    );

    typedef struct packed {
        logic [2:0] st;
        logic       en;
        logic       seg;
        logic [7:0] n;
        logic [3:0] np;
        logic [3:0] na;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 1'b1, 1'b0, 8'd30, 4'd0, 4'd0},  // R11 closed
        '{3'd1, 1'b1, 1'b0, 8'd30, 4'd0, 4'd0},  // R11 listening
        '{3'd2, 1'b1, 1'b0, 8'd10, 4'd0, 4'd0},  // R7 opening, short of timeout
        '{3'd3, 1'b1, 1'b0, 8'd19, 4'd0, 4'd0},  // R2 established, short of period
        '{3'd3, 1'b1, 1'b1, 8'd19, 4'd0, 4'd0},  // R5 segment restarts
        '{3'd3, 1'b1, 1'b0, 8'd2,  4'd1, 4'd0},  // R2 first probe
        '{3'd3, 1'b1, 1'b0, 8'd24, 4'd3, 4'd1},  // R3 R4 retries, drop
        '{3'd3, 1'b1, 1'b0, 8'd40, 4'd0, 4'd0},  // R4 silent once spent
        '{3'd4, 1'b1, 1'b0, 8'd16, 4'd0, 4'd1},  // R7 closing timeout
        '{3'd4, 1'b1, 1'b0, 8'd30, 4'd0, 4'd0},  // R7 only once
        '{3'd3, 1'b0, 1'b0, 8'd60, 4'd0, 4'd0},  // R6 keepalive disabled
        '{3'd0, 1'b1, 1'b0, 8'd5,  4'd0, 4'd0}   // R11 closed again
    };

    // Record one comparison and report a mismatch.
    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one rising edge and sample the outputs at the next falling edge.
    task automatic tick(output logic p, output logic a);
        @(posedge clk);
        @(negedge clk);
        p = probe_req;
        a = abort_req;
        if ((p && a) || (p && last_p) || (a && last_a)) r10_bad++;
        last_p = p;
        last_a = a;
    endtask

    // Compare one sampled edge against the expectation.
    task automatic cmp_edge(input string req, input int k, input logic p, input logic a,
                            input logic ep, input logic ea);
        n_cmp++;
        if (p !== ep || a !== ea) begin
            n_bad++;
            $display("FAIL %s: edge %0d actual probe=%0b abort=%0b expected probe=%0b abort=%0b",
                     req, k, p, a, ep, ea);
        end
    endtask

    function automatic logic exp_probe(input int k);
        return (k == P) || (k > P && k <= P + L * R && ((k - P) % R) == 0);
    endfunction

    function automatic logic exp_abort(input int k);
        return k == P + (L + 1) * R;
    endfunction

    function automatic string ka_tag(input int k);
        if (k <= P) return "R2";
        if (k <= P + L * R) return "R3";
        return "R4";
    endfunction

    // Return to the closed state for a few edges between tests.
    task automatic settle();
        logic p, a;
        conn_state = 3'd0;
        ka_en = 1'b1;
        seg_rx = 1'b0;
        for (int i = 0; i < 3; i++) tick(p, a);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic p, a;
        int cp, ca;

        // R1: reset holds both outputs low even with a handshake state present.
        conn_state = 3'd2;
        cp = 0; ca = 0;
        for (int i = 0; i < 25; i++) begin
            tick(p, a);
            cp += int'(p);
            ca += int'(a);
        end
        check(cp == 0, "R1 probe in reset", cp, 0);
        check(ca == 0, "R1 abort in reset", ca, 0);
        conn_state = 3'd0;
        tick(p, a);
        rst_n = 1'b1;
        tick(p, a);

        // Table walk: pulse counts per stimulus row.
        for (int r = 0; r < NROWS; r++) begin
            conn_state = ROWS[r].st;
            ka_en      = ROWS[r].en;
            seg_rx     = ROWS[r].seg;
            cp = 0; ca = 0;
            for (int i = 0; i < int'(ROWS[r].n); i++) begin
                tick(p, a);
                seg_rx = 1'b0;
                cp += int'(p);
                ca += int'(a);
            end
            check(cp == int'(ROWS[r].np), $sformatf("row %0d probes", r), cp, int'(ROWS[r].np));
            check(ca == int'(ROWS[r].na), $sformatf("row %0d aborts", r), ca, int'(ROWS[r].na));
        end

        // R2 R3 R4: exact edges of the full keepalive sequence.
        settle();
        conn_state = 3'd3;
        for (int k = 0; k < 60; k++) begin
            tick(p, a);
            cmp_edge(ka_tag(k), k, p, a, exp_probe(k), exp_abort(k));
        end

        // R7 R8: opening then closing; the watchdog restarts on the change.
        settle();
        conn_state = 3'd2;
        for (int k = 0; k < 10; k++) begin
            tick(p, a);
            cmp_edge("R7", k, p, a, 1'b0, 1'b0);
        end
        conn_state = 3'd4;
        for (int k = 0; k < 20; k++) begin
            tick(p, a);
            cmp_edge("R8", k, p, a, 1'b0, k == T);
        end

        // R9: leaving the established state and re-entering gives a full period.
        settle();
        conn_state = 3'd3;
        for (int k = 0; k < 15; k++) begin
            tick(p, a);
            cmp_edge("R9", k, p, a, 1'b0, 1'b0);
        end
        conn_state = 3'd0;
        for (int k = 0; k < 3; k++) begin
            tick(p, a);
            cmp_edge("R9", k, p, a, 1'b0, 1'b0);
        end
        conn_state = 3'd3;
        for (int k = 0; k < 22; k++) begin
            tick(p, a);
            cmp_edge("R9", k, p, a, k == P, 1'b0);
        end

        // R5: a segment during retries restarts the period and the retry count.
        settle();
        conn_state = 3'd3;
        for (int k = 0; k < 28; k++) begin
            tick(p, a);
            cmp_edge(ka_tag(k), k, p, a, exp_probe(k), exp_abort(k));
        end
        seg_rx = 1'b1;
        for (int k = 0; k < 46; k++) begin
            tick(p, a);
            seg_rx = 1'b0;
            cmp_edge("R5", k, p, a, exp_probe(k), exp_abort(k));
        end

        // R6: dropping the enable clears; restoring it starts a full period.
        settle();
        conn_state = 3'd3;
        for (int k = 0; k < 15; k++) begin
            tick(p, a);
            cmp_edge("R6", k, p, a, 1'b0, 1'b0);
        end
        ka_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick(p, a);
            cmp_edge("R6", k, p, a, 1'b0, 1'b0);
        end
        ka_en = 1'b1;
        for (int j = 1; j <= 21; j++) begin
            tick(p, a);
            cmp_edge("R6", j, p, a, j == P, 1'b0);
        end

        // R10: single-cycle, mutually exclusive pulses across the whole run.
        check(r10_bad == 0, "R10 pulse shape violations", r10_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule